// File: doc/BRIEF.md
# 3x3 Median Image Filter Engine

This engine denoises one grayscale frame held in an external pixel memory. On request it walks the image in raster order. It fetches the pixels it needs over a read-only address/data port, keeps a 3x3 neighbourhood in registers and writes the median of that neighbourhood to an external result memory. Each result goes to the address of the centre pixel. Neighbours that fall outside the frame take the value zero and are never fetched, so the output frame has the same size as the input frame.

A frame starts when `frame_go` is seen high while the engine is idle. `frame_busy` then stays high until the last result has been handed to the result memory. The pixel memory is expected to return the data for the presented address after the next falling clock edge. The engine consumes it on the following rising edge. Each output pixel costs four clock cycles: three fetch slots for the new window column, plus one cycle that finishes the capture and shifts the window. At row starts one extra column is primed.

Top module: `medfilt3_engine`

## Requirements
- R1: While reset is asserted and after it is released, `frame_busy` and `res_we` are low and `pix_addr` is 0.
- R2: From idle, `frame_busy` rises on the first rising clock edge at which `frame_go` is sampled high.
- R3: `frame_busy` falls on the clock edge after the cycle in which the write to the last address (W*H-1) is presented. By then all W*H results of the frame have been written.
- R4: `pix_addr` is registered. The value on `pix_data` is consumed on the rising edge that follows the edge that issued the address. Data valid from the falling edge in between is sufficient.
- R5: Window taps outside the image read as 0. For a uniform image of value 255, the four corner results are 0 and every other result is 255.
- R6: No fetch is issued for a padded tap: `pix_addr` holds its value in such slots. Each image column is fetched once per window row that covers it, so a frame issues W*(3H-2) real fetches. The number of `pix_addr` value changes equals that count, less one when the first fetch (address 0) equals the address already held.
- R7: The value written for pixel (row, col) is the 5th smallest of the nine zero-padded neighbourhood values. Equal values are allowed.
- R8: In one frame, every result address row*W+col is written exactly once, in ascending order. `res_we` is a single-cycle pulse that is never high on two consecutive cycles.
- R9: `res_we` is never high while `frame_busy` is low.
- R10: `frame_go` has no effect while busy; frames do not restart or overlap. While idle with `frame_go` low, the engine stays idle.
- R11: After a frame completes, raising `frame_go` again processes a new frame from the current pixel memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| frame_go | input | 1 | Request to process the frame held in pixel memory |
| frame_busy | output | 1 | High from frame start until the last result is written |
| pix_addr | output | AW (14) | Pixel memory address, row*W+col |
| pix_data | input | PW (8) | Pixel value for `pix_addr`, valid after the falling edge |
| res_rdata | input | PW (8) | Result memory read data (not needed by the filter) |
| res_addr | output | AW (14) | Result memory address |
| res_wdata | output | PW (8) | Result value to write |
| res_we | output | 1 | Result write enable; low means read |

## Verification
Checked on every cycle by assertions:
- writes only while busy;
- single-cycle write pulses at strictly ascending addresses;
- busy rising only after a sampled request and falling only right after the final address is written;
- the fetch address held in padded slots;
- exactly one window tap selected as the median.

Only the bench's scenarios can show:
- the correctness of each median value against a model;
- the zero-padding pattern on a uniform frame;
- the total fetch count;
- that every address is written once;
- that a second frame runs after the first.

// File: rtl/medfilt3_pkg.sv
package medfilt3_pkg;
  localparam int TAPS     = 9;
  localparam int MID_RANK = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/medfilt3_rank_sel.sv
module medfilt3_rank_sel
  import medfilt3_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic [9*PW-1:0]   taps,
  output logic [PW-1:0]     med
);
  logic [PW-1:0]   v    [TAPS];
  logic [3:0]      rank [TAPS];
  logic [TAPS-1:0] hit;

  for (genvar gi = 0; gi < TAPS; gi++) begin : g_unpack
    assign v[gi] = taps[gi*PW +: PW];
  end

  // Stable rank: ties broken by tap index, so exactly one tap has rank 4.
  always_comb begin
    med = '0;
    for (int i = 0; i < TAPS; i++) begin
      rank[i] = '0;
      for (int j = 0; j < TAPS; j++) begin
        if (j != i && (v[j] < v[i] || (v[j] == v[i] && j < i))) begin
          rank[i] = rank[i] + 4'd1;
        end
      end
      hit[i] = (rank[i] == 4'(MID_RANK));
      if (hit[i]) med = v[i];
    end
  end

  AST_ONE_MEDIAN: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> ($countones(hit) == 1)); // R7
endmodule

// File: rtl/medfilt3_window.sv
module medfilt3_window #(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            cap_en,
  input  logic [1:0]      cap_slot,
  input  logic            cap_pad,
  input  logic [PW-1:0]   pix_in,
  input  logic            shift,
  output logic [9*PW-1:0] taps
);
  // win[col][row]: col 0 = left, col 2 = newest
  logic [2:0][2:0][PW-1:0] win;
  logic [1:0][PW-1:0]      stage;
  logic [PW-1:0]           cap_val;

  assign cap_val = cap_pad ? '0 : pix_in;
  assign taps    = win;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      win   <= '0;
      stage <= '0;
    end else if (clear) begin
      win   <= '0;
      stage <= '0;
    end else begin
      if (cap_en && cap_slot != 2'd2) stage[cap_slot[0]] <= cap_val;
      if (shift) begin
        win[0]    <= win[1];
        win[1]    <= win[2];
        win[2][0] <= stage[0];
        win[2][1] <= stage[1];
        win[2][2] <= cap_val;
      end
    end
  end
endmodule

// File: rtl/medfilt3_seq.sv
module medfilt3_seq
  import medfilt3_pkg::*;
#(
  parameter int W  = 128,
  parameter int H  = 128,
  parameter int AW = $clog2(W*H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] fetch_addr,
  output logic          cap_en,
  output logic [1:0]    cap_slot,
  output logic          cap_pad,
  output logic          shift,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_last
);
  localparam int CW = $clog2(W+1);
  localparam int RW = $clog2(H);
  localparam int AX = AW + 1;

  seq_state_e     st;
  logic [RW-1:0]  row;
  logic [CW-1:0]  fcol;
  logic [1:0]     k;
  logic           pad_q;
  logic [AW-1:0]  addr_q;
  logic           edge_col, last_row, oob;
  logic [AX-1:0]  base, fetch_a;

  assign edge_col = (fcol == CW'(W));
  assign last_row = (row == RW'(H-1));
  assign oob      = edge_col || (k == 2'd0 && row == '0) || (k == 2'd2 && last_row);
  assign base     = AX'(row) * AX'(W) + AX'(fcol);

  always_comb begin
    case (k)
      2'd0:    fetch_a = base - AX'(W);
      2'd2:    fetch_a = base + AX'(W);
      default: fetch_a = base;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st     <= SQ_IDLE;
      row    <= '0;
      fcol   <= '0;
      k      <= '0;
      pad_q  <= 1'b1;
      addr_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st   <= SQ_RUN;
          row  <= '0;
          fcol <= '0;
          k    <= '0;
        end
        SQ_RUN: begin
          if (k != 2'd3) begin
            pad_q <= oob;
            if (!oob) addr_q <= fetch_a[AW-1:0];
            k <= k + 2'd1;
          end else begin
            k <= '0;
            if (edge_col) begin
              fcol <= '0;
              if (last_row) st <= SQ_DONE;
              else          row <= row + 1'b1;
            end else begin
              fcol <= fcol + 1'b1;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign fetch_addr = addr_q;
  assign cap_en     = (st == SQ_RUN) && (k != 2'd0);
  assign cap_slot   = k - 2'd1;
  assign cap_pad    = pad_q;
  assign shift      = (st == SQ_RUN) && (k == 2'd3);
  assign out_valid  = shift && (fcol != '0);
  assign out_addr   = AW'(base - AX'(1));
  assign out_last   = shift && edge_col && last_row;

  AST_PAD_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_RUN && k != 2'd3 && oob) |=> $stable(fetch_addr)); // R6
endmodule

// File: rtl/medfilt3_engine.sv
module medfilt3_engine #(
  parameter int IMG_W = 128,
  parameter int IMG_H = 128,
  parameter int PW    = 8,
  parameter int AW    = $clog2(IMG_W*IMG_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_go,
  output logic          frame_busy,
  output logic [AW-1:0] pix_addr,
  input  logic [PW-1:0] pix_data,
  input  logic [PW-1:0] res_rdata,
  output logic [AW-1:0] res_addr,
  output logic [PW-1:0] res_wdata,
  output logic          res_we
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(IMG_W*IMG_H-1);

  logic          busy_q, start;
  logic          cap_en, cap_pad, shift, out_valid, out_last;
  logic [1:0]    cap_slot;
  logic [AW-1:0] out_addr, pend_addr, waddr_q;
  logic          wr_pend, last_pend, we_q, last_q;
  logic [PW-1:0] wdata_q, med;
  logic [9*PW-1:0] taps;
  logic          unused_rdata;

  assign unused_rdata = ^res_rdata;
  assign start        = !busy_q && frame_go;

  medfilt3_seq #(.W(IMG_W), .H(IMG_H), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fetch_addr(pix_addr),
    .cap_en(cap_en), .cap_slot(cap_slot), .cap_pad(cap_pad), .shift(shift),
    .out_valid(out_valid), .out_addr(out_addr), .out_last(out_last)
  );

  medfilt3_window #(.PW(PW)) u_win (
    .clk(clk), .rst(rst), .clear(start), .cap_en(cap_en), .cap_slot(cap_slot),
    .cap_pad(cap_pad), .pix_in(pix_data), .shift(shift), .taps(taps)
  );

  medfilt3_rank_sel #(.PW(PW)) u_med (
    .clk(clk), .rst(rst), .chk_en(wr_pend), .taps(taps), .med(med)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy_q    <= 1'b0;
      wr_pend   <= 1'b0;
      last_pend <= 1'b0;
      pend_addr <= '0;
      we_q      <= 1'b0;
      last_q    <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      if (start)               busy_q <= 1'b1;
      else if (we_q && last_q) busy_q <= 1'b0;
      wr_pend   <= out_valid;
      last_pend <= out_last;
      if (out_valid) pend_addr <= out_addr;
      we_q   <= wr_pend;
      last_q <= last_pend;
      if (wr_pend) begin
        waddr_q <= pend_addr;
        wdata_q <= med;
      end
    end
  end

  assign frame_busy = busy_q;
  assign res_we     = we_q;
  assign res_addr   = waddr_q;
  assign res_wdata  = wdata_q;

  // checker state: address of the previous write within the frame
  logic          have_prev;
  logic [AW-1:0] prev_wa;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_wa   <= '0;
    end else if (start) begin
      have_prev <= 1'b0;
    end else if (res_we) begin
      have_prev <= 1'b1;
      prev_wa   <= res_addr;
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_we |-> frame_busy); // R9
  AST_BUSY_ON_GO: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_busy) |-> $past(frame_go)); // R2
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (res_we && have_prev) |-> (res_addr == prev_wa + 1'b1)); // R8
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_we |=> !res_we); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_busy) |-> ($past(res_we) && $past(res_addr) == LAST_ADDR)); // R3
endmodule

// File: tb/medfilt3_engine_tb_top.sv
`timescale 1ns/1ps
module medfilt3_engine_tb_top;
  localparam int W = 128, H = 128, N = W*H, AW = 14, PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_go = 1'b0;
  logic          frame_busy;
  logic [AW-1:0] pix_addr, res_addr;
  logic [PW-1:0] pix_data = '0;
  logic [PW-1:0] res_rdata, res_wdata;
  logic          res_we;

  always #2.5 clk = ~clk;

  logic [7:0] img [N];
  logic [7:0] res [N];
  int         wcnt [N];
  int checks = 0, errors = 0;
  int n_writes = 0, order_bad = 0, idle_we = 0, addr_chg = 0;
  logic [AW-1:0] last_wa = '0, prev_ia = '0;
  bit finished = 0;

  medfilt3_engine dut_i (
    .clk(clk), .rst(rst), .frame_go(frame_go), .frame_busy(frame_busy),
    .pix_addr(pix_addr), .pix_data(pix_data), .res_rdata(res_rdata),
    .res_addr(res_addr), .res_wdata(res_wdata), .res_we(res_we)
  );

  // pixel memory: data follows the address after the falling edge
  always @(negedge clk) pix_data <= img[pix_addr];
  assign res_rdata = res[res_addr];

  // result memory and port monitors, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (res_we) begin
        if (!frame_busy) idle_we++;
        if (n_writes > 0 && res_addr != last_wa + 1'b1) order_bad++;
        res[res_addr] = res_wdata;
        wcnt[res_addr]++;
        n_writes++;
        last_wa = res_addr;
      end
      if (pix_addr != prev_ia) addr_chg++;
      prev_ia = pix_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gold(input int r, input int c);
    int v[9];
    int n = 0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int rr = r + dr;
        int cc = c + dc;
        v[n] = (rr < 0 || rr >= H || cc < 0 || cc >= W) ? 0 : int'(img[rr*W+cc]);
        n++;
      end
    end
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 8 - i; j++) begin
        if (v[j] > v[j+1]) begin
          int t = v[j];
          v[j] = v[j+1];
          v[j+1] = t;
        end
      end
    end
    return v[4];
  endfunction

  task automatic run_frame(input string tag, input int exp_chg);
    int cyc = 0;
    int bad = 0;
    int mm = 0;
    int mm_act = 0, mm_exp = 0;
    for (int a = 0; a < N; a++) begin
      res[a] = 8'h5A;
      wcnt[a] = 0;
    end
    n_writes = 0; order_bad = 0; addr_chg = 0; idle_we = 0;
    @(negedge clk) frame_go = 1'b1;
    @(negedge clk);
    chk(frame_busy == 1'b1, "R2 R11", {tag, " busy after go"}, frame_busy, 1);
    // keep go high while busy: must not restart (R10)
    repeat (60) @(negedge clk);
    frame_go = 1'b0;
    while (frame_busy && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    chk(!frame_busy, "R3", {tag, " busy fell"}, frame_busy, 0);
    chk(n_writes == N, "R3", {tag, " writes at busy fall"}, n_writes, N);
    for (int a = 0; a < N; a++) if (wcnt[a] != 1) bad++;
    chk(bad == 0, "R8 R10", {tag, " addresses not written once"}, bad, 0);
    chk(order_bad == 0, "R8", {tag, " write order breaks"}, order_bad, 0);
    chk(idle_we == 0, "R9", {tag, " writes while idle"}, idle_we, 0);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int g = gold(r, c);
        if (int'(res[r*W+c]) != g) begin
          if (mm == 0) begin
            mm_act = int'(res[r*W+c]);
            mm_exp = g;
          end
          mm++;
        end
      end
    end
    chk(mm == 0, "R4 R7", {tag, " first median mismatch"}, mm_act, mm_exp);
    chk(addr_chg == exp_chg, "R6", {tag, " fetch address changes"}, addr_chg, exp_chg);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(!frame_busy && !res_we, "R1", "busy/we in reset", {frame_busy, res_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!frame_busy && !res_we, "R1", "busy/we after reset", {frame_busy, res_we}, 0);
    chk(pix_addr == '0, "R1", "pix_addr after reset", pix_addr, 0);
  endtask

  task automatic test_idle_hold();
    int w0 = n_writes;
    int seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (frame_busy) seen++;
    end
    chk(seen == 0, "R10", "busy while go low", seen, 0);
    chk(n_writes == w0, "R9", "writes while idle", n_writes - w0, 0);
  endtask

  task automatic test_noisy_frame();
    int s = 12345;
    for (int a = 0; a < N; a++) begin
      s = s * 1103515245 + 12345;
      case ((s >>> 16) & 63)
        0:       img[a] = 8'd255;
        1:       img[a] = 8'd0;
        default: img[a] = 8'(((a / W) * 3 + (a % W) * 5 + ((s >>> 8) & 7)));
      endcase
    end
    // first real fetch is address 0, equal to the reset value: one less change
    run_frame("noisy", W*(3*H-2) - 1);
  endtask

  task automatic test_flat_frame();
    for (int a = 0; a < N; a++) img[a] = 8'd255;
    run_frame("flat", W*(3*H-2));
    chk(res[0] == 8'd0, "R5", "top-left corner", res[0], 0);
    chk(res[W-1] == 8'd0, "R5", "top-right corner", res[W-1], 0);
    chk(res[N-W] == 8'd0, "R5", "bottom-left corner", res[N-W], 0);
    chk(res[N-1] == 8'd0, "R5", "bottom-right corner", res[N-1], 0);
    chk(res[5] == 8'd255, "R5", "top edge", res[5], 255);
    chk(res[5*W] == 8'd255, "R5", "left edge", res[5*W], 255);
    chk(res[64*W+64] == 8'd255, "R5", "interior", res[64*W+64], 255);
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin
      img[a] = '0;
      res[a] = '0;
      wcnt[a] = 0;
    end
    test_reset();
    test_idle_hold();
    test_noisy_frame();
    test_idle_hold();
    test_flat_frame();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule